// File: doc/BRIEF.md
# Banked Register Window Selector

This block lets a bus master configure four identical copies of a peripheral's register set through a single narrow address window. A control register at offset 0x00 holds a 2-bit bank select. Four 32-bit data registers appear at offsets 0x10 to 0x1C. Every access to that window lands in the bank named by the current select value. All sixteen stored words are driven out in parallel, so each peripheral copy wires directly to its own slice and always sees its own settings.

The bus is a plain single-cycle register port: address, write strobe with write data, and read strobe. Read data is registered and shows up one clock after the read strobe. It then holds until the next read. The bus has no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `bank_window`

## Requirements
- R1: While reset is low, the select value, all sixteen bank words and the read data clear to zero.
- R2: The control register is at offset 0x00, and bits [1:0] of a write there become the select value. A read of 0x00 returns the select value in bits [1:0], with bits [31:2] reading as zero.
- R3: A write to offset 0x10, 0x14, 0x18 or 0x1C stores the write data in register index (offset-0x10)/4 of the bank named by the select value.
- R4: A window write leaves the three unselected banks, and the other registers of the selected bank, unchanged.
- R5: A read of a window offset returns the addressed register of the selected bank.
- R6: A new select value applies to the very next access. A window read issued in the cycle after the control write returns the newly selected bank.
- R7: Any offset other than 0x00 and the four aligned window offsets is unmapped. Unaligned offsets such as 0x12 count as unmapped. A read of an unmapped offset returns zero, and a write there changes neither the select value nor any bank word.
- R8: Read data is valid one clock after the read strobe and holds its value while no read strobe is present.
- R9: When a read and a write to the same offset happen in one cycle, the read returns the contents from before the write.
- R10: Output bank_regs carries bank b, register r at bits [(b*4+r)*32 +: 32], and bank_sel carries the current select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bank_sel | output | 2 | Current bank select value |
| bank_regs | output | 512 | All bank words, bank-major, register-minor |

## Verification
A wrong select value or a misrouted write shows up at once on bank_regs, one clock after the faulty write. For this reason the bench compares the whole parallel output against its model after every write, instead of waiting for a read to expose the error. A fault in the read multiplexer only shows up on bus_rdata, one clock after a read strobe. Each read is therefore scored against a queued prediction, including reads issued right after a select change and reads that share a cycle with a write.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;

  // Result of decoding one bus offset
  typedef struct packed {
    logic ctrl_hit;  // offset selects the control register
    logic win_hit;   // offset lands inside the shared window
  } dec_hit_t;

endpackage

// File: rtl/bank_window_decode.sv
module bank_window_decode
  import bank_window_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFF = 'h00,
  parameter int WIN_BASE = 'h10,
  parameter int REGS     = 4,
  parameter int IDX_W    = $clog2(REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_hit_t          hit,
  output logic [IDX_W-1:0]  idx
);

  localparam int WIN_SPAN = REGS * 4;

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel          = addr - ADDR_W'(WIN_BASE);
    hit.ctrl_hit = (addr == ADDR_W'(CTRL_OFF));
    hit.win_hit  = (addr >= ADDR_W'(WIN_BASE)) &&
                   (rel < ADDR_W'(WIN_SPAN)) &&
                   (rel[1:0] == 2'b00);
    idx          = rel[IDX_W+1:2];
  end

endmodule

// File: rtl/bank_window_bank.sv
module bank_window_bank #(
  parameter int DATA_W = 32,
  parameter int REGS   = 4,
  parameter int IDX_W  = $clog2(REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [REGS*DATA_W-1:0] regs_o
);

  for (genvar r = 0; r < REGS; r++) begin : g_word
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(r))) begin
        word_q <= wr_data;
      end
    end

    assign regs_o[r*DATA_W +: DATA_W] = word_q;
  end

endmodule

// File: rtl/bank_window_rdmux.sv
module bank_window_rdmux
  import bank_window_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int REGS      = 4,
  parameter int SEL_W     = $clog2(NUM_BANKS),
  parameter int IDX_W     = $clog2(REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  dec_hit_t                         hit,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [NUM_BANKS*REGS*DATA_W-1:0] words,
  output logic [DATA_W-1:0]                rdata
);

  logic [SEL_W+IDX_W-1:0] flat_idx;
  logic [DATA_W-1:0]      win_word;

  always_comb begin
    flat_idx = {sel, idx};
    win_word = words[flat_idx*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (hit.ctrl_hit)     rdata <= DATA_W'(sel);
      else if (hit.win_hit) rdata <= win_word;
      else                  rdata <= '0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit.ctrl_hit && !hit.win_hit) |=> (rdata == '0)); // R7

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit.ctrl_hit) |=> (rdata == DATA_W'($past(sel)))); // R2

endmodule

// File: rtl/bank_window.sv
module bank_window
  import bank_window_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int REGS      = 4,
  parameter int CTRL_OFF  = 'h00,
  parameter int WIN_BASE  = 'h10,
  parameter int SEL_W     = $clog2(NUM_BANKS),
  parameter int IDX_W     = $clog2(REGS),
  parameter int BANK_BITS = REGS * DATA_W,
  parameter int ALL_BITS  = NUM_BANKS * BANK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [SEL_W-1:0]    bank_sel,
  output logic [ALL_BITS-1:0] bank_regs
);

  dec_hit_t         hit;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel_q;
  logic             win_wr;

  bank_window_decode #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFF(CTRL_OFF),
    .WIN_BASE(WIN_BASE),
    .REGS    (REGS),
    .IDX_W   (IDX_W)
  ) u_decode (
    .addr(bus_addr),
    .hit (hit),
    .idx (idx)
  );

  // Select register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (bus_wr && hit.ctrl_hit) begin
      sel_q <= bus_wdata[SEL_W-1:0];
    end
  end

  assign bank_sel = sel_q;
  assign win_wr   = bus_wr && hit.win_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = win_wr && (sel_q == SEL_W'(b));

    bank_window_bank #(
      .DATA_W(DATA_W),
      .REGS  (REGS),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_we),
      .wr_idx (idx),
      .wr_data(bus_wdata),
      .regs_o (bank_regs[b*BANK_BITS +: BANK_BITS])
    );

    AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hit.win_hit && (bank_sel == SEL_W'(b)))
        |=> $stable(bank_regs[b*BANK_BITS +: BANK_BITS])); // R4

    for (genvar r = 0; r < REGS; r++) begin : g_chk
      AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit.win_hit && (bank_sel == SEL_W'(b)) && (idx == IDX_W'(r)))
          |=> (bank_regs[(b*REGS+r)*DATA_W +: DATA_W] == $past(bus_wdata))); // R3
    end
  end

  bank_window_rdmux #(
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS),
    .REGS     (REGS),
    .SEL_W    (SEL_W),
    .IDX_W    (IDX_W)
  ) u_rdmux (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_en(bus_rd),
    .hit  (hit),
    .idx  (idx),
    .sel  (sel_q),
    .words(bank_regs),
    .rdata(bus_rdata)
  );

  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit.ctrl_hit) |=> (bank_sel == $past(bus_wdata[SEL_W-1:0]))); // R2

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit.ctrl_hit) |=> $stable(bank_sel)); // R7

endmodule

// File: tb/bank_window_test.sv
module bank_window_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [31:0]  bus_rdata;
  logic [1:0]   bank_sel;
  logic [511:0] bank_regs;

  int checks = 0;
  int failures = 0;

  logic [31:0] model [4][4];
  logic [1:0]  msel;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  bank_window uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .bank_sel (bank_sel),
    .bank_regs(bank_regs)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] predict_read(input logic [7:0] a);
    if (a == 8'h00) return {30'd0, msel};
    if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00) return model[msel][(a - 8'h10) >> 2];
    return 32'd0;
  endfunction

  // Driver: one bus cycle, starting and ending at a falling edge
  task automatic access(input logic [7:0] a, input logic wr, input logic [31:0] d,
                        input logic rd, input string tag);
    bus_addr  = a;
    bus_wr    = wr;
    bus_wdata = d;
    bus_rd    = rd;
    if (rd) begin
      exp_q.push_back(predict_read(a));
      tag_q.push_back(tag);
    end
    if (wr) begin
      if (a == 8'h00) msel = d[1:0];
      else if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00) model[msel][(a - 8'h10) >> 2] = d;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " bank_sel"}, {30'd0, bank_sel}, {30'd0, msel});
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        check($sformatf("%s R10 bank%0d reg%0d", tag, b, r),
              bank_regs[(b*4+r)*32 +: 32], model[b][r]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    msel  = '0;
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++) model[b][r] = '0;
    repeat (2) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 32'd0);
    check_outputs("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Monitor: scores each registered read one clock after its strobe
  always @(posedge clk) begin
    if (rst_n && bus_rd) begin
      #2;
      if (exp_q.size() == 0) begin
        check("R8 unexpected read", bus_rdata, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    msel = '0;
    @(negedge clk);
    do_reset();

    access(8'h00, 1'b0, '0, 1'b1, "R1 ctrl after reset");
    access(8'h10, 1'b0, '0, 1'b1, "R1 window after reset");

    // Fill every bank with distinct values
    for (int b = 0; b < 4; b++) begin
      access(8'h00, 1'b1, 32'(b), 1'b0, "R2 sel write");
      for (int r = 0; r < 4; r++) begin
        access(8'h10 + 8'(4*r), 1'b1, 32'hA500_0000 | 32'(b << 8) | 32'(r), 1'b0, "R3 fill");
        check_outputs("R3 R4 after write");
      end
    end

    // Select change then immediate window read
    for (int b = 3; b >= 0; b--) begin
      access(8'h00, 1'b1, 32'(b), 1'b0, "R6 sel");
      access(8'h14, 1'b0, '0, 1'b1, "R6 read right after select");
      access(8'h1C, 1'b0, '0, 1'b1, "R5 window read");
    end

    // Back-to-back reads across offsets
    access(8'h10, 1'b0, '0, 1'b1, "R5 b2b read 0x10");
    access(8'h18, 1'b0, '0, 1'b1, "R5 b2b read 0x18");

    // Upper control bits ignored
    access(8'h00, 1'b1, 32'hFFFF_FFFE, 1'b0, "R2 wide write");
    access(8'h00, 1'b0, '0, 1'b1, "R2 ctrl readback");
    check_outputs("R2 after wide write");

    // Unmapped offsets
    access(8'h04, 1'b1, 32'hDEAD_0001, 1'b0, "R7 wr 04");
    access(8'h0C, 1'b1, 32'hDEAD_0003, 1'b0, "R7 wr 0C");
    access(8'h12, 1'b1, 32'hDEAD_0012, 1'b0, "R7 wr 12");
    access(8'h20, 1'b1, 32'hDEAD_0020, 1'b0, "R7 wr 20");
    access(8'hFC, 1'b1, 32'hDEAD_00FC, 1'b0, "R7 wr FC");
    check_outputs("R7 after unmapped writes");
    access(8'h08, 1'b0, '0, 1'b1, "R7 rd 08");
    access(8'h12, 1'b0, '0, 1'b1, "R7 rd 12");
    access(8'h20, 1'b0, '0, 1'b1, "R7 rd 20");

    // Same-cycle read and write
    access(8'h18, 1'b1, 32'h1234_5678, 1'b1, "R9 rd+wr same cycle");
    access(8'h18, 1'b0, '0, 1'b1, "R9 read after");
    check_outputs("R9 outputs");

    // Hold while idle
    access(8'h1C, 1'b0, '0, 1'b1, "R8 read before idle");
    bus_addr = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 hold while idle", bus_rdata, model[msel][3]);

    // Reset mid-run
    do_reset();
    access(8'h1C, 1'b0, '0, 1'b1, "R1 window after second reset");

    repeat (2) @(negedge clk);
    check("R8 queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule